// File: doc/BRIEF.md
# Gated-Clock Parallel-Load Shift Register

This block is a parallel-in, serial-out shift register of eight stages by default. On an active clock edge it does one of two things. It can capture a whole word from the parallel inputs. It can also move every stage one place toward the output, with a new bit taken from the serial input. Only the last stage drives the output pin, so a word that is loaded in parallel leaves one bit per edge, highest-numbered bit first.

Clocking is built around a single free-running system clock. A clock-inhibit input pauses the register without stopping that clock. When the inhibit is sampled high on a rising edge, that edge is suppressed and all stages keep their contents. The inhibit must only be raised while the clock is high, so raising it never makes an extra edge.

An active-low clear acts at once and asynchronously. It drives every stage to zero and wins over the clock, the inhibit, the mode select and all data inputs for as long as it is held low.

Top module: `gsr_top`

## Requirements
- R1: While `clr_n` is low, `q_out` is 0 without waiting for a clock edge. After the clear, every stage is zero, so eight shifts with `ser_in` at 0 give only 0s at `q_out`.
- R2: While `clr_n` is low, rising clock edges change nothing, whatever the mode, data and inhibit inputs are.
- R3: When `shift_ld` is 0 (load) and `inhibit` is 0, a rising edge copies `par_in[i]` into stage i. Stage 0 is the first stage and stage 7 is the last. `q_out` changes only at that edge and then shows `par_in[7]`.
- R4: During a load, `ser_in` has no effect. Stage 0 gets `par_in[0]`.
- R5: When `shift_ld` is 1 (shift) and `inhibit` is 0, each rising edge moves stage i-1 into stage i and `ser_in` into stage 0. After a load of word v, the next seven shift edges give v[6], v[5] … v[0] at `q_out`.
- R6: A bit placed on `ser_in` during a shift edge reaches `q_out` after eight shift edges. Bits come out in the order they went in.
- R7: A rising edge with `inhibit` sampled high leaves every stage unchanged.
- R8: While `inhibit` is high, changes on `shift_ld`, `ser_in` and `par_in` have no effect on the stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock; rising edge is the active edge |
| clr_n | input | 1 | Asynchronous clear, active low, overrides all other inputs |
| inhibit | input | 1 | Clock inhibit; high suppresses the update at the edge |
| shift_ld | input | 1 | Mode select: 1 = shift, 0 = parallel load |
| ser_in | input | 1 | Serial data entering stage 0 during shifts |
| par_in | input | WIDTH | Parallel data; bit i loads stage i |
| q_out | output | 1 | Content of the last stage |

## Verification
Every possible 8-bit word is loaded and shifted out in full. This separates a correct stage order and load mapping from one that is swapped or off by one. During those loads, `ser_in` is held at the opposite of `par_in[0]`, so any leak of serial data into the load shows up. Serial fills use a spread of bytes with mixed bit patterns, which checks the entry order apart from the load path. Inhibit windows, with the other inputs toggling, and a clear applied in the middle of a shift separate a true hold from a stale output, and an asynchronous clear from a synchronous one.

// File: rtl/gsr_pkg.sv
package gsr_pkg;
  typedef enum logic {
    MODE_LOAD  = 1'b0,
    MODE_SHIFT = 1'b1
  } mode_e;
endpackage

// File: rtl/gsr_ctrl.sv
module gsr_ctrl
  import gsr_pkg::*;
(
  input  logic inhibit,
  input  logic shift_ld,
  output logic load_en,
  output logic shift_en
);
  mode_e mode;

  always_comb begin
    mode     = mode_e'(shift_ld);
    load_en  = !inhibit && (mode == MODE_LOAD);
    shift_en = !inhibit && (mode == MODE_SHIFT);
  end
endmodule

// File: rtl/gsr_next.sv
module gsr_next #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] par,
  input  logic             ser,
  input  logic             load_en,
  input  logic             shift_en,
  output logic [WIDTH-1:0] nxt,
  output logic             upd
);
  logic [WIDTH-1:0] prev_bit;

  assign prev_bit[0] = ser;

  generate
    for (genvar i = 1; i < WIDTH; i++) begin : g_link
      assign prev_bit[i] = cur[i-1];
    end
    for (genvar i = 0; i < WIDTH; i++) begin : g_sel
      always_comb begin
        if (load_en)       nxt[i] = par[i];
        else if (shift_en) nxt[i] = prev_bit[i];
        else               nxt[i] = cur[i];
      end
    end
  endgenerate

  assign upd = load_en || shift_en;
endmodule

// File: rtl/gsr_stages.sv
module gsr_stages #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             upd,
  input  logic [WIDTH-1:0] nxt,
  output logic [WIDTH-1:0] stage
);
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)   stage <= '0;
    else if (upd) stage <= nxt;
  end
endmodule

// File: rtl/gsr_top.sv
module gsr_top #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             inhibit,
  input  logic             shift_ld,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] par_in,
  output logic             q_out
);
  localparam int LAST = WIDTH - 1;

  logic             load_en;
  logic             shift_en;
  logic             upd;
  logic [WIDTH-1:0] nxt;
  logic [WIDTH-1:0] stage;

  gsr_ctrl u_ctrl (
    .inhibit  (inhibit),
    .shift_ld (shift_ld),
    .load_en  (load_en),
    .shift_en (shift_en)
  );

  gsr_next #(.WIDTH(WIDTH)) u_next (
    .cur      (stage),
    .par      (par_in),
    .ser      (ser_in),
    .load_en  (load_en),
    .shift_en (shift_en),
    .nxt      (nxt),
    .upd      (upd)
  );

  gsr_stages #(.WIDTH(WIDTH)) u_stages (
    .clk   (clk),
    .clr_n (clr_n),
    .upd   (upd),
    .nxt   (nxt),
    .stage (stage)
  );

  assign q_out = stage[LAST];

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!clr_n)
    $rose(clr_n) |-> stage == '0); // R1

  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!clr_n)
    (!inhibit && !shift_ld) |=> stage == $past(par_in)); // R3

  AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (!clr_n)
    (!inhibit && shift_ld) |=> (stage[0] == $past(ser_in)) &&
                               (stage[LAST:1] == $past(stage[LAST-1:0]))); // R5

  AST_INHIBIT_HOLD: assert property (@(posedge clk) disable iff (!clr_n)
    inhibit |=> $stable(stage)); // R7
endmodule

// File: tb/tb_gsr_top.sv
module tb_gsr_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         clr_n = 1'b1;
  logic         inhibit = 1'b0;
  logic         shift_ld = 1'b1;
  logic         ser_in = 1'b0;
  logic [W-1:0] par_in = '0;
  logic         q_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  gsr_top #(.WIDTH(W)) dut (
    .clk(clk), .clr_n(clr_n), .inhibit(inhibit), .shift_ld(shift_ld),
    .ser_in(ser_in), .par_in(par_in), .q_out(q_out)
  );

  always #2 clk = ~clk;

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: q_out=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // advance to 1 ns after the next rising edge (clock is high then)
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #1 clr_n = 1'b0;
    #1;
    check("R1", q_out, 1'b0);
    tick(); tick();
    clr_n = 1'b1;
    tick();

    // R3 R4 R5: every word loaded and shifted out
    for (int v = 0; v < 256; v++) begin
      logic [7:0] b;
      b = v[7:0];
      shift_ld = 1'b0; par_in = b; ser_in = ~b[0];
      #1;
      check("R3", q_out, (v == 0) ? 1'b0 : 1'b0 | (v > 0 ? ((v-1) & 1) : 0));
      tick();
      check("R3", q_out, b[7]);
      shift_ld = 1'b1; par_in = ~b;
      for (int k = 6; k >= 0; k--) begin
        ser_in = b[k];
        tick();
        check("R5", q_out, b[k]);
      end
    end

    // R4: serial input ignored during load
    shift_ld = 1'b0; par_in = 8'h00; ser_in = 1'b1;
    tick();
    shift_ld = 1'b1; ser_in = 1'b1;
    for (int k = 0; k < 7; k++) tick();
    check("R4", q_out, 1'b0);

    // R6: serial fills
    for (int s = 0; s < 256; s += 17) begin
      logic [7:0] p;
      p = s[7:0] ^ 8'h5A;
      shift_ld = 1'b1;
      for (int k = 7; k >= 0; k--) begin
        ser_in = p[k];
        tick();
      end
      check("R6", q_out, p[7]);
      ser_in = 1'b0;
      for (int k = 6; k >= 0; k--) begin
        tick();
        check("R6", q_out, p[k]);
      end
    end

    // R7 R8: inhibit holds the word while other inputs toggle
    shift_ld = 1'b0; par_in = 8'hB3; ser_in = 1'b0;
    tick();
    check("R7", q_out, 1'b1);
    inhibit = 1'b1;
    for (int k = 0; k < 5; k++) begin
      shift_ld = k[0]; ser_in = ~k[0]; par_in = 8'h00 | k[7:0];
      tick();
      check("R8", q_out, 1'b1);
    end
    inhibit = 1'b0; shift_ld = 1'b1; ser_in = 1'b0;
    for (int k = 6; k >= 0; k--) begin
      tick();
      check("R7", q_out, 8'hB3 >> k & 1'b1);
    end

    // R1 R2: clear in the middle of a shift
    shift_ld = 1'b0; par_in = 8'hFF;
    tick();
    shift_ld = 1'b1; ser_in = 1'b1;
    tick(); tick(); tick();
    check("R5", q_out, 1'b1);
    clr_n = 1'b0;
    #1;
    check("R1", q_out, 1'b0);
    shift_ld = 1'b0;
    tick();
    check("R2", q_out, 1'b0);
    shift_ld = 1'b1;
    tick();
    check("R2", q_out, 1'b0);
    #1 clr_n = 1'b1;
    ser_in = 1'b0;
    for (int k = 0; k < 8; k++) begin
      tick();
      check("R1", q_out, 1'b0);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: q_out=%0b expected completion", q_out);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule